// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the bit clock and the frame sync of a multi-slot serial audio link on the clock-master side. One of four master clock inputs is picked by a select field. The bit clock is an even division of that source. The overall ratio is `2*(DIV+1)`, so it ranges from 2 to 512 with an 8-bit divider field. A frame holds a programmable number of slots of a programmable width, and the frame sync pulse is shaped by three controls: its width in bits, an early flag that moves it one bit clock ahead of the frame, and a polarity flag. Used together, these controls give the usual framing styles:

- left-justified: width = slot width, not early, active high
- I2S: width = slot width, early, active low
- DSP-A: width 1, early, active high
- DSP-B: width 1, not early, active high

The master clock inputs are sampled in the system clock domain, and the generator advances on their rising edges. For every serial bit the block emits a one-cycle strobe together with the slot index and the bit position, so that a data serializer can load or shift the matching bit. Configuration is expected to stay stable while the generator runs. When the enable drops, the generator completes the current frame, parks the bit clock and the frame sync at their idle levels, and waits for the next enable.

Top module: `afs_frame_gen`

## Requirements
- R1: `bclk` has a period of 2*(`bclk_div`+1) rising edges of `mclk_src[mclk_sel]`; each source index 0..3 selects its own input.
- R2: The idle level of `bclk` equals `bclk_invert`. Each bit strobe occurs while `bclk` is at its idle level, so with `bclk_invert`=0 a new bit starts on a falling edge.
- R3: Each serial bit gives one `bit_stb` pulse. `bit_idx` counts 0..W-1 within a slot, and then `slot_idx` steps by one, where W is `slot_width`. A `slot_count` of 0 or 1 behaves as 2.
- R4: A frame is exactly (effective slots) × W bits long.
- R5: With `sync_early`=0, the sync is active for the frame bits b < `sync_width`, where b = `slot_idx`*W + `bit_idx`. With `sync_width` = W this is the left-justified pulse.
- R6: With `sync_early`=1, the sync is active for b+1 < `sync_width` and during the last bit of the preceding frame. This gives I2S (width W) and DSP-A (width 1).
- R7: With `sync_width`=1 and `sync_early`=0, the sync is active only on bit 0 of slot 0 (DSP-B).
- R8: `fsync` = active ^ `fs_invert`. While idle or in reset, `fsync` equals `fs_invert`.
- R9: After `enable` falls, the current frame completes and the generator stops at the frame boundary. The early pulse is dropped in that final bit, and no further strobes follow.
- R10: When `enable` is asserted while idle, the first strobe reports slot 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_src | input | 4 | Candidate master clocks, sampled in the `clk` domain |
| mclk_sel | input | 2 | Master clock source select |
| bclk_div | input | 8 | Half-period of the bit clock minus one, in master clock edges |
| slot_count | input | 4 | Slots per frame (0 and 1 behave as 2) |
| slot_width | input | 6 | Bits per slot |
| sync_width | input | 6 | Frame sync pulse width in bits |
| sync_early | input | 1 | Assert the sync one bit clock before the frame |
| fs_invert | input | 1 | Make the frame sync active low |
| bclk_invert | input | 1 | Invert the bit clock |
| enable | input | 1 | Run request; a clean stop completes the frame |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| bit_stb | output | 1 | One-cycle strobe at the start of every bit |
| slot_idx | output | 3 | Slot index of the current bit |
| bit_idx | output | 5 | Bit position of the current bit within its slot |

## Verification
Two functions meet in the last bit of a frame: the wrap or stop decision, and the early sync pulse of the next frame. In early mode both depend on the enable value captured when that bit starts. The bench provokes this by dropping `enable` during the third frame of every run. It then checks that the third frame's final bit carries no early pulse while the two preceding wraps do, and that the strobe count stops at exactly three frames. The same sweep covers all four framing styles over several slot counts and widths, including the one-slot case that must behave as two.

// File: rtl/afs_pkg.sv
package afs_pkg;
   typedef enum logic {
      AFS_IDLE = 1'b0,
      AFS_RUN  = 1'b1
   } afs_state_e;
endpackage

// File: rtl/afs_mclk_select.sv
module afs_mclk_select #(
   parameter int SEL_W = 2,
   localparam int SRC_N = 2 ** SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [SRC_N-1:0] rise_v;

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      logic [2:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[1:0], src[i]};
      end
      assign rise_v[i] = sh_q[1] & ~sh_q[2];
   end

   assign tick = rise_v[sel];
endmodule

// File: rtl/afs_bclk_div.sv
module afs_bclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             bclk_q,
   output logic             fall
);
   logic [DIV_W-1:0] cnt_q;
   logic             half_done;

   assign half_done = tick && (cnt_q == div);
   assign fall      = run && half_done && bclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (tick) begin
         if (half_done) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R1: the bit clock only moves on an edge of the selected source
   assert_bclk_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk_q != $past(bclk_q)) |-> $past(tick));
endmodule

// File: rtl/afs_frame_ctr.sv
module afs_frame_ctr
   import afs_pkg::*;
#(
   parameter int MAX_SLOTS = 8,
   parameter int MAX_WIDTH = 32,
   localparam int SIDX_W = $clog2(MAX_SLOTS),
   localparam int BIDX_W = $clog2(MAX_WIDTH),
   localparam int SLOT_W = SIDX_W + 1,
   localparam int WID_W  = BIDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              advance,
   input  logic [SLOT_W-1:0] slot_count,
   input  logic [WID_W-1:0]  slot_width,
   input  logic [WID_W-1:0]  sync_width,
   input  logic              sync_early,
   output logic              running,
   output logic              bit_stb,
   output logic [SIDX_W-1:0] slot_idx,
   output logic [BIDX_W-1:0] bit_idx,
   output logic              fs_raw
);
   localparam int FB_W  = SIDX_W + BIDX_W;
   localparam int FBX_W = FB_W + 1;

   afs_state_e        state_q;
   logic [SIDX_W-1:0] slot_q, nx_slot;
   logic [BIDX_W-1:0] bit_q, nx_bit;
   logic [FB_W-1:0]   fb_q;
   logic              wrap_ok_q, stb_q;
   logic [SLOT_W-1:0] es;
   logic [WID_W-1:0]  ew;
   logic              bit_last, slot_last, at_last;
   logic [FBX_W-1:0]  fbx, swx;

   // effective frame geometry
   always_comb begin
      if (slot_count < SLOT_W'(2))              es = SLOT_W'(2);
      else if (slot_count > SLOT_W'(MAX_SLOTS)) es = SLOT_W'(MAX_SLOTS);
      else                                      es = slot_count;
      if (slot_width == '0)                     ew = WID_W'(1);
      else if (slot_width > WID_W'(MAX_WIDTH))  ew = WID_W'(MAX_WIDTH);
      else                                      ew = slot_width;
   end

   assign bit_last  = ({1'b0, bit_q}  == ew - WID_W'(1));
   assign slot_last = ({1'b0, slot_q} == es - SLOT_W'(1));
   assign at_last   = bit_last && slot_last;

   always_comb begin
      if (bit_last) begin
         nx_bit  = '0;
         nx_slot = slot_q + 1'b1;
      end else begin
         nx_bit  = bit_q + 1'b1;
         nx_slot = slot_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= AFS_IDLE;
         slot_q    <= '0;
         bit_q     <= '0;
         fb_q      <= '0;
         wrap_ok_q <= 1'b0;
         stb_q     <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         case (state_q)
            AFS_IDLE: begin
               if (enable) begin
                  state_q   <= AFS_RUN;
                  slot_q    <= '0;
                  bit_q     <= '0;
                  fb_q      <= '0;
                  wrap_ok_q <= 1'b0;
                  stb_q     <= 1'b1;
               end
            end
            default: begin
               if (advance) begin
                  wrap_ok_q <= enable;
                  if (at_last) begin
                     slot_q <= '0;
                     bit_q  <= '0;
                     fb_q   <= '0;
                     if (wrap_ok_q) stb_q   <= 1'b1;
                     else           state_q <= AFS_IDLE;
                  end else begin
                     slot_q <= nx_slot;
                     bit_q  <= nx_bit;
                     fb_q   <= fb_q + 1'b1;
                     stb_q  <= 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign running  = (state_q == AFS_RUN);
   assign bit_stb  = stb_q;
   assign slot_idx = slot_q;
   assign bit_idx  = bit_q;

   assign fbx = {1'b0, fb_q};
   assign swx = FBX_W'(sync_width);

   always_comb begin
      if (!running)        fs_raw = 1'b0;
      else if (sync_early) fs_raw = ((fbx + FBX_W'(1)) < swx) || (at_last && wrap_ok_q);
      else                 fs_raw = (fbx < swx);
   end

   // R9: a stop only happens out of the last bit of a frame
   assert_stop_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(at_last));
   // R10: a fresh start reports the frame origin with a strobe
   assert_start_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (bit_stb && slot_idx == '0 && bit_idx == '0));
   // R3: indices stay inside the programmed frame
   assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> ({1'b0, bit_idx} < ew && {1'b0, slot_idx} < es));
   // R5: the sync level only moves at bit starts
   assert_sync_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !bit_stb) |-> $stable(fs_raw));
endmodule

// File: rtl/afs_frame_gen.sv
module afs_frame_gen #(
   parameter int SEL_W     = 2,
   parameter int DIV_W     = 8,
   parameter int MAX_SLOTS = 8,
   parameter int MAX_WIDTH = 32,
   localparam int SRC_N  = 2 ** SEL_W,
   localparam int SIDX_W = $clog2(MAX_SLOTS),
   localparam int BIDX_W = $clog2(MAX_WIDTH),
   localparam int SLOT_W = SIDX_W + 1,
   localparam int WID_W  = BIDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  mclk_src,
   input  logic [SEL_W-1:0]  mclk_sel,
   input  logic [DIV_W-1:0]  bclk_div,
   input  logic [SLOT_W-1:0] slot_count,
   input  logic [WID_W-1:0]  slot_width,
   input  logic [WID_W-1:0]  sync_width,
   input  logic              sync_early,
   input  logic              fs_invert,
   input  logic              bclk_invert,
   input  logic              enable,
   output logic              bclk,
   output logic              fsync,
   output logic              bit_stb,
   output logic [SIDX_W-1:0] slot_idx,
   output logic [BIDX_W-1:0] bit_idx
);
   if (MAX_SLOTS < 2 || (1 << SIDX_W) != MAX_SLOTS) begin : g_bad_slots
      $error("MAX_SLOTS must be a power of two of at least 2");
   end
   if (MAX_WIDTH < 2 || (1 << BIDX_W) != MAX_WIDTH) begin : g_bad_width
      $error("MAX_WIDTH must be a power of two of at least 2");
   end
   if (DIV_W < 1 || SEL_W < 1) begin : g_bad_div
      $error("DIV_W and SEL_W must be positive");
   end

   logic mclk_tick, bclk_q, bit_fall, running, fs_raw, stb;

   afs_mclk_select #(.SEL_W(SEL_W)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (mclk_src),
      .sel   (mclk_sel),
      .tick  (mclk_tick)
   );

   afs_bclk_div #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (mclk_tick),
      .run    (running),
      .div    (bclk_div),
      .bclk_q (bclk_q),
      .fall   (bit_fall)
   );

   afs_frame_ctr #(.MAX_SLOTS(MAX_SLOTS), .MAX_WIDTH(MAX_WIDTH)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .advance    (bit_fall),
      .slot_count (slot_count),
      .slot_width (slot_width),
      .sync_width (sync_width),
      .sync_early (sync_early),
      .running    (running),
      .bit_stb    (stb),
      .slot_idx   (slot_idx),
      .bit_idx    (bit_idx),
      .fs_raw     (fs_raw)
   );

   assign bclk    = bclk_q ^ bclk_invert;
   assign fsync   = fs_raw ^ fs_invert;
   assign bit_stb = stb;

   // R2: an idle generator holds the bit clock at its idle level
   assert_bclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (bclk == bclk_invert));
   // R2: every bit begins in the low phase of the internal bit clock
   assert_stb_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> !bclk_q);
   // R8: an idle generator holds the sync at its inactive level
   assert_fsync_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (fsync == fs_invert));
endmodule

// File: tb/afs_frame_gen_bench.sv
module afs_frame_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mclk_src = '0;
   logic [1:0] mclk_sel = '0;
   logic [7:0] bclk_div = '0;
   logic [3:0] slot_count = 4'd2;
   logic [5:0] slot_width = 6'd2;
   logic [5:0] sync_width = 6'd1;
   logic       sync_early = 1'b0;
   logic       fs_invert = 1'b0;
   logic       bclk_invert = 1'b0;
   logic       enable = 1'b0;
   logic       bclk, fsync, bit_stb;
   logic [2:0] slot_idx;
   logic [4:0] bit_idx;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   int mc_cnt [4];

   afs_frame_gen u_afs_frame_gen (
      .clk(clk), .rst_n(rst_n), .mclk_src(mclk_src), .mclk_sel(mclk_sel),
      .bclk_div(bclk_div), .slot_count(slot_count), .slot_width(slot_width),
      .sync_width(sync_width), .sync_early(sync_early), .fs_invert(fs_invert),
      .bclk_invert(bclk_invert), .enable(enable), .bclk(bclk), .fsync(fsync),
      .bit_stb(bit_stb), .slot_idx(slot_idx), .bit_idx(bit_idx)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // source i toggles every i+1 system clocks
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (mc_cnt[i] >= i) begin
            mc_cnt[i]   <= 0;
            mclk_src[i] <= ~mclk_src[i];
         end else begin
            mc_cnt[i] <= mc_cnt[i] + 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic period_run(input int s, input int d);
      int rises = 0;
      int t0 = 0, t1 = 0, t2 = 0;
      logic prev;
      mclk_sel = 2'(s);
      bclk_div = 8'(d);
      slot_count = 4'd2; slot_width = 6'd2; sync_width = 6'd1;
      sync_early = 1'b0; fs_invert = 1'b0; bclk_invert = 1'b0;
      enable = 1'b1;
      prev = bclk;
      for (int t = 0; t < 2000 && rises < 3; t++) begin
         @(negedge clk);
         if (bclk && !prev) begin
            if (rises == 0) t0 = cyc;
            else if (rises == 1) t1 = cyc;
            else t2 = cyc;
            rises++;
         end
         prev = bclk;
      end
      chk("R1 period a", t1 - t0, 4 * (d + 1) * (s + 1));
      chk("R1 period b", t2 - t1, 4 * (d + 1) * (s + 1));
      enable = 1'b0;
      repeat (700) @(negedge clk);
      chk("R2 idle bclk", int'(bclk), 0);
   endtask

   task automatic frame_run(input int style, input int slots_in, input int w);
      int es, len, b, f, n, gap, sw;
      logic early, finv, exp_act;
      string tag;
      es = (slots_in < 2) ? 2 : slots_in;
      len = es * w;
      case (style)
         0: begin sw = w; early = 1'b0; finv = 1'b0; tag = "R5"; end
         1: begin sw = w; early = 1'b1; finv = 1'b1; tag = "R6"; end
         2: begin sw = 1; early = 1'b1; finv = 1'b0; tag = "R6"; end
         default: begin sw = 1; early = 1'b0; finv = 1'b0; tag = "R7"; end
      endcase
      mclk_sel = 2'd0; bclk_div = 8'd0;
      slot_count = 4'(slots_in); slot_width = 6'(w); sync_width = 6'(sw);
      sync_early = early; fs_invert = finv; bclk_invert = style[0];
      @(negedge clk);
      chk("R8 idle fsync", int'(fsync), int'(finv));
      enable = 1'b1;
      b = 0; f = 0; n = 0; gap = 0;
      for (int t = 0; t < 4000; t++) begin
         @(negedge clk);
         if (bit_stb) begin
            gap = 0;
            chk((n == 0) ? "R10 slot" : "R3 slot", int'(slot_idx), b / w);
            chk((n == 0) ? "R10 bit" : "R3 bit", int'(bit_idx), b % w);
            chk("R2 strobe phase", int'(bclk), int'(style[0]));
            if (early) exp_act = (b + 1 < sw) || (b == len - 1 && f < 2);
            else       exp_act = (b < sw);
            chk(tag, int'(fsync), int'(exp_act ^ finv));
            n++; b++;
            if (b == len) begin b = 0; f++; end
            if (f == 2 && b == 1) enable = 1'b0;
         end else begin
            gap++;
         end
         if (n >= 3 * len && gap > 40) break;
      end
      chk("R4 R9 strobe total", n, 3 * len);
      chk("R9 stopped fsync", int'(fsync), int'(finv));
      chk("R9 stopped bclk", int'(bclk), int'(style[0]));
   endtask

   initial begin
      wait (cyc >= 150000);
      n_fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R8 reset fsync", int'(fsync), 0);
      chk("R2 reset bclk", int'(bclk), 0);
      chk("R3 reset strobe", int'(bit_stb), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2 idle bclk", int'(bclk), 0);
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 4; d += (d == 0) ? 1 : 2)
            period_run(s, d);
      for (int st = 0; st < 4; st++)
         for (int sl = 1; sl <= 3; sl++)
            for (int w = 3; w <= 4; w++)
               frame_run(st, sl, w);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule